// File: doc/BRIEF.md
# Memory-Mapped I/O Device Bridge

The bridge sits on a processor's data-memory port and splits every load and store between a small on-chip data RAM and a handful of device registers. Any address at or above 0xA0000000 belongs to the device window. Every lower address goes to RAM. Inside the device window, a fixed word address selects one of five devices:

- a read-only 32-bit microsecond runtime counter;
- a 16-bit LED register that can be read and written;
- the switch input vector;
- the button input vector;
- a write-only serial output port.

Loads are answered combinationally from registered state, so read data is valid in the same cycle as the address. The selected device or RAM word is narrowed to the byte or halfword lane that the access size and the low address bits pick. A word store to the serial port produces a one-cycle strobe that carries the low data byte. The strobe drives an external serializer. Switches and buttons arrive already synchronized.

Top module: `mmio_bridge`

## Requirements
- R1: An address of 0xA0000000 or above is device space and a lower address is RAM. Addresses up to 0x9FFFFFFC reach RAM, and RAM is indexed by the word address modulo its depth. A store in device space never changes RAM contents.
- R2: Access size is encoded 0 = byte, 1 = halfword, 2 or 3 = word. A word load returns the full word. A halfword load returns the half picked by address bit 1 in bits 15:0. A byte load returns the byte picked by address bits 1:0 in bits 7:0. All bits above the returned data are zero.
- R3: The runtime counter is read as a word at 0xA0000048. It is 0 after reset and increments by exactly one every CLK_PER_US clock cycles.
- R4: The LED register is at 0xA0000400. A halfword or word store there loads store data bits 15:0 into `led_out`. A load there returns the register in bits 15:0. A byte store there has no effect.
- R5: A load from 0xA0000500 returns `sw_in` zero-extended. A load from 0xA0000600 returns `btn_in` zero-extended.
- R6: A word store to 0xA00003F8 raises `tx_valid` for exactly the following cycle, with `tx_data` equal to store data bits 7:0. A byte or halfword store there raises no strobe. A load there returns zero.
- R7: Stores to the counter, switch and button addresses are ignored. Loads from unmapped device addresses return zero.
- R8: Reset is synchronous and active high. It clears `led_out`, `tx_valid` and the runtime counter.
- R9: A RAM store writes only the bytes its size and low address bits select. Byte store data comes from bits 7:0 and halfword store data from bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | input | 32 | Byte address of the access |
| mem_we | input | 1 | Store enable |
| mem_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| mem_wdata | input | 32 | Store data, right-aligned |
| mem_rdata | output | 32 | Load data, right-aligned, zero-extended |
| sw_in | input | SW_W | Synchronized switch levels |
| btn_in | input | BTN_W | Synchronized button levels |
| led_out | output | LED_W | LED register state |
| tx_valid | output | 1 | One-cycle serial byte strobe |
| tx_data | output | 8 | Serial byte |

## Verification
The bench targets the RAM/device boundary by storing at 0x9FFFFFFC and reading the aliased RAM word back. A decoder whose boundary is off would send that store to the device space and lose the data. It stores to an unmapped device address that shares low bits with a live RAM word. A bridge that lets device stores reach RAM would corrupt that word. Byte and halfword lanes are checked on both reads and writes, because a wrong lane shift returns a neighbouring byte or clobbers one. The bench also checks that byte stores to the LED register and half stores to the serial port are ignored. It measures the counter over a fixed window that includes a store to the counter, so a wrong prescale or a writable counter shows up as a wrong difference.

// File: rtl/mmio_pkg.sv
package mmio_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD2 = 2'd3
  } acc_size_e;

  localparam logic [31:0] IO_BASE     = 32'hA000_0000;
  localparam logic [31:0] TIMER_ADDR  = 32'hA000_0048;
  localparam logic [31:0] SERIAL_ADDR = 32'hA000_03F8;
  localparam logic [31:0] LED_ADDR    = 32'hA000_0400;
  localparam logic [31:0] SW_ADDR     = 32'hA000_0500;
  localparam logic [31:0] BTN_ADDR    = 32'hA000_0600;

  typedef struct packed {
    logic ram;
    logic timer;
    logic led;
    logic sw;
    logic btn;
    logic serial;
  } dev_sel_t;

endpackage

// File: rtl/mmio_addr_decode.sv
module mmio_addr_decode
  import mmio_pkg::*;
(
  input  logic [31:0] addr,
  output dev_sel_t    sel
);

  logic in_io;

  always_comb begin
    in_io      = (addr >= IO_BASE);
    sel.ram    = !in_io;
    sel.timer  = in_io && (addr[31:2] == TIMER_ADDR[31:2]);
    sel.led    = in_io && (addr[31:2] == LED_ADDR[31:2]);
    sel.sw     = in_io && (addr[31:2] == SW_ADDR[31:2]);
    sel.btn    = in_io && (addr[31:2] == BTN_ADDR[31:2]);
    sel.serial = in_io && (addr[31:2] == SERIAL_ADDR[31:2]);
  end

endmodule

// File: rtl/mmio_us_timer.sv
module mmio_us_timer #(
  parameter int CLK_PER_US = 50,
  parameter int CNT_W      = 32
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] us_count
);

  logic tick;

  generate
    if (CLK_PER_US > 1) begin : g_prescale
      localparam int PS_W = $clog2(CLK_PER_US);
      localparam logic [PS_W-1:0] PS_LAST = PS_W'(CLK_PER_US - 1);
      logic [PS_W-1:0] ps_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          ps_q <= '0;
        end else if (ps_q == PS_LAST) begin
          ps_q <= '0;
        end else begin
          ps_q <= ps_q + 1'b1;
        end
      end

      assign tick = (ps_q == PS_LAST);

      p_prescale_range_r3: assert property (@(posedge clk) disable iff (rst)
        ps_q <= PS_LAST);
    end else begin : g_direct
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      us_count <= '0;
    end else if (tick) begin
      us_count <= us_count + 1'b1;
    end
  end

  // R3: outside reset the counter only ever steps up by one
  p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (us_count != $past(us_count))) |-> (us_count == $past(us_count) + 1'b1));

endmodule

// File: rtl/mmio_dev_regs.sv
module mmio_dev_regs
  import mmio_pkg::*;
#(
  parameter int LED_W = 16,
  parameter int SW_W  = 16,
  parameter int BTN_W = 4,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  dev_sel_t         sel,
  input  logic             we,
  input  acc_size_e        size,
  input  logic [31:0]      wdata,
  input  logic [CNT_W-1:0] us_count,
  input  logic [SW_W-1:0]  sw_in,
  input  logic [BTN_W-1:0] btn_in,
  output logic [31:0]      rd_word,
  output logic [LED_W-1:0] led_out,
  output logic             tx_valid,
  output logic [7:0]       tx_data
);

  logic led_wr;
  logic ser_wr;

  assign led_wr = we && sel.led && (size != SZ_BYTE);
  assign ser_wr = we && sel.serial && ((size == SZ_WORD) || (size == SZ_WRD2));

  always_ff @(posedge clk) begin
    if (rst) begin
      led_out <= '0;
    end else if (led_wr) begin
      led_out <= wdata[LED_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= ser_wr;
      if (ser_wr) begin
        tx_data <= wdata[7:0];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (sel.timer) rd_word = 32'(us_count);
    if (sel.led)   rd_word = 32'(led_out);
    if (sel.sw)    rd_word = 32'(sw_in);
    if (sel.btn)   rd_word = 32'(btn_in);
  end

  // R4: the LED register changes only after a qualifying store
  p_led_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(led_wr)) |-> $stable(led_out));

  // R6: a strobe is always caused by a word store to the serial port one cycle earlier
  p_tx_cause_r6: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> ($past(ser_wr) && !$past(rst)));

endmodule

// File: rtl/mmio_ram.sv
module mmio_ram #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [3:0]    be,
  input  logic [AW-1:0] idx,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);

  localparam int DEPTH = 1 << AW;

  generate
    for (genvar g = 0; g < 4; g++) begin : g_lane
      logic [7:0] mem [DEPTH];

      always_ff @(posedge clk) begin
        if (we && be[g]) begin
          mem[idx] <= wdata[8*g +: 8];
        end
      end

      assign rdata[8*g +: 8] = mem[idx];
    end
  endgenerate

endmodule

// File: rtl/mmio_bridge.sv
module mmio_bridge
  import mmio_pkg::*;
#(
  parameter int CLK_PER_US = 50,
  parameter int RAM_AW     = 8,
  parameter int LED_W      = 16,
  parameter int SW_W       = 16,
  parameter int BTN_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [31:0]      mem_addr,
  input  logic             mem_we,
  input  logic [1:0]       mem_size,
  input  logic [31:0]      mem_wdata,
  output logic [31:0]      mem_rdata,
  input  logic [SW_W-1:0]  sw_in,
  input  logic [BTN_W-1:0] btn_in,
  output logic [LED_W-1:0] led_out,
  output logic             tx_valid,
  output logic [7:0]       tx_data
);

  localparam int CNT_W = 32;

  dev_sel_t         sel;
  acc_size_e        size;
  logic [CNT_W-1:0] us_count;
  logic [31:0]      dev_word;
  logic [31:0]      ram_word;
  logic [31:0]      lane_wdata;
  logic [3:0]       lane_be;
  logic [31:0]      sel_word;
  logic [31:0]      shifted;

  assign size = acc_size_e'(mem_size);

  mmio_addr_decode u_dec (
    .addr (mem_addr),
    .sel  (sel)
  );

  mmio_us_timer #(
    .CLK_PER_US (CLK_PER_US),
    .CNT_W      (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .us_count (us_count)
  );

  // Spread store data across the lanes and pick byte enables
  always_comb begin
    case (size)
      SZ_BYTE: begin
        lane_wdata = {4{mem_wdata[7:0]}};
        lane_be    = 4'b0001 << mem_addr[1:0];
      end
      SZ_HALF: begin
        lane_wdata = {2{mem_wdata[15:0]}};
        lane_be    = mem_addr[1] ? 4'b1100 : 4'b0011;
      end
      default: begin
        lane_wdata = mem_wdata;
        lane_be    = 4'b1111;
      end
    endcase
  end

  mmio_ram #(
    .AW (RAM_AW)
  ) u_ram (
    .clk   (clk),
    .we    (mem_we && sel.ram),
    .be    (lane_be),
    .idx   (mem_addr[RAM_AW+1:2]),
    .wdata (lane_wdata),
    .rdata (ram_word)
  );

  mmio_dev_regs #(
    .LED_W (LED_W),
    .SW_W  (SW_W),
    .BTN_W (BTN_W),
    .CNT_W (CNT_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .we       (mem_we),
    .size     (size),
    .wdata    (lane_wdata),
    .us_count (us_count),
    .sw_in    (sw_in),
    .btn_in   (btn_in),
    .rd_word  (dev_word),
    .led_out  (led_out),
    .tx_valid (tx_valid),
    .tx_data  (tx_data)
  );

  // Pick the source word, then narrow it to the addressed lane
  always_comb begin
    sel_word = sel.ram ? ram_word : dev_word;
    shifted  = sel_word >> {mem_addr[1:0], 3'b000};
    case (size)
      SZ_BYTE: mem_rdata = {24'b0, shifted[7:0]};
      SZ_HALF: mem_rdata = {16'b0, shifted[15:0]};
      default: mem_rdata = sel_word;
    endcase
  end

  // R1: an access targets at most one region
  p_single_target_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel.ram, sel.timer, sel.led, sel.sw, sel.btn, sel.serial}));

endmodule

// File: tb/mmio_bridge_bench.sv
module mmio_bridge_bench;

  localparam int CLK_PERIOD = 10;
  localparam int US_DIV     = 4;
  localparam int NV         = 21;

  typedef struct packed {
    logic        we;
    logic [1:0]  sz;
    logic [31:0] addr;
    logic [31:0] wd;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd2, 32'h0000_0010, 32'h1122_3344, 32'h0},
    '{1'b0, 2'd2, 32'h0000_0010, 32'h0,         32'h1122_3344},
    '{1'b0, 2'd1, 32'h0000_0012, 32'h0,         32'h0000_1122},
    '{1'b0, 2'd0, 32'h0000_0011, 32'h0,         32'h0000_0033},
    '{1'b1, 2'd0, 32'h0000_0013, 32'h0000_00AA, 32'h0},
    '{1'b0, 2'd2, 32'h0000_0010, 32'h0,         32'hAA22_3344},
    '{1'b1, 2'd2, 32'hA000_0010, 32'hDEAD_BEEF, 32'h0},
    '{1'b0, 2'd2, 32'h0000_0010, 32'h0,         32'hAA22_3344},
    '{1'b0, 2'd2, 32'hA000_0010, 32'h0,         32'h0},
    '{1'b1, 2'd1, 32'hA000_0400, 32'h0000_BEEF, 32'h0},
    '{1'b0, 2'd1, 32'hA000_0400, 32'h0,         32'h0000_BEEF},
    '{1'b1, 2'd0, 32'hA000_0400, 32'h0000_0012, 32'h0},
    '{1'b0, 2'd2, 32'hA000_0400, 32'h0,         32'h0000_BEEF},
    '{1'b0, 2'd1, 32'hA000_0500, 32'h0,         32'h0000_5A3C},
    '{1'b0, 2'd2, 32'hA000_0600, 32'h0,         32'h0000_0009},
    '{1'b1, 2'd2, 32'hA000_0500, 32'hFFFF_FFFF, 32'h0},
    '{1'b0, 2'd1, 32'hA000_0500, 32'h0,         32'h0000_5A3C},
    '{1'b0, 2'd2, 32'hA000_03F8, 32'h0,         32'h0},
    '{1'b0, 2'd1, 32'hA000_0402, 32'h0,         32'h0},
    '{1'b1, 2'd2, 32'h9FFF_FFFC, 32'hCAFE_F00D, 32'h0},
    '{1'b0, 2'd2, 32'h0000_03FC, 32'h0,         32'hCAFE_F00D}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] mem_addr = '0;
  logic        mem_we = 1'b0;
  logic [1:0]  mem_size = 2'd2;
  logic [31:0] mem_wdata = '0;
  logic [31:0] mem_rdata;
  logic [15:0] sw_in = 16'h5A3C;
  logic [3:0]  btn_in = 4'h9;
  logic [15:0] led_out;
  logic        tx_valid;
  logic [7:0]  tx_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tags [NV] = '{"R9", "R9", "R2", "R2", "R9", "R9", "R1", "R1", "R7", "R4", "R4",
                       "R4", "R4", "R5", "R5", "R7", "R7", "R6", "R2", "R1", "R1"};

  always #(CLK_PERIOD/2) clk = ~clk;

  mmio_bridge #(
    .CLK_PER_US (US_DIV)
  ) u_mmio_bridge (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_size  (mem_size),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .sw_in     (sw_in),
    .btn_in    (btn_in),
    .led_out   (led_out),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [1:0] sz, input logic [31:0] a,
                       input logic [31:0] d);
    @(negedge clk);
    mem_we    = we;
    mem_size  = sz;
    mem_addr  = a;
    mem_wdata = d;
  endtask

  initial begin
    logic [31:0] t0;
    logic [31:0] t1;
    // R8: state while reset is held
    repeat (3) @(posedge clk);
    drive(1'b0, 2'd2, 32'hA000_0048, 32'h0);
    #1;
    check("R8 timer in reset", mem_rdata, 32'h0);
    check("R8 led in reset", 32'(led_out), 32'h0);
    check("R8 tx_valid in reset", 32'(tx_valid), 32'h0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].we, VEC[i].sz, VEC[i].addr, VEC[i].wd);
      if (!VEC[i].we) begin
        #1;
        check(tags[i], mem_rdata, VEC[i].exp);
      end
    end
    drive(1'b0, 2'd2, 32'h0, 32'h0);
    #1;
    check("R4 led_out port", 32'(led_out), 32'h0000_BEEF);

    // R6: word store raises the strobe on the next cycle only
    drive(1'b1, 2'd2, 32'hA000_03F8, 32'h1234_5641);
    @(posedge clk);
    #1;
    check("R6 strobe high", 32'(tx_valid), 32'h1);
    check("R6 strobe byte", 32'(tx_data), 32'h41);
    drive(1'b0, 2'd2, 32'h0, 32'h0);
    @(posedge clk);
    #1;
    check("R6 strobe single cycle", 32'(tx_valid), 32'h0);
    drive(1'b1, 2'd1, 32'hA000_03F8, 32'h0000_0077);
    @(posedge clk);
    #1;
    check("R6 half store no strobe", 32'(tx_valid), 32'h0);

    // R3 and R7: counter rate over a window that contains a store to it
    drive(1'b0, 2'd2, 32'hA000_0048, 32'h0);
    #1;
    t0 = mem_rdata;
    repeat (5) @(posedge clk);
    drive(1'b1, 2'd2, 32'hA000_0048, 32'h0000_0000);
    drive(1'b1, 2'd2, 32'hA000_0600, 32'h0000_0000);
    repeat (34) @(posedge clk);
    drive(1'b0, 2'd2, 32'hA000_0048, 32'h0);
    #1;
    t1 = mem_rdata;
    check("R3 R7 counter advance over 40 cycles", t1 - t0, 32'd10);
    drive(1'b0, 2'd2, 32'hA000_0600, 32'h0);
    #1;
    check("R7 buttons after store", mem_rdata, 32'h9);

    // R5: new input levels seen on the next load
    sw_in  = 16'hFFFF;
    btn_in = 4'h6;
    drive(1'b0, 2'd2, 32'hA000_0500, 32'h0);
    #1;
    check("R5 switches word", mem_rdata, 32'h0000_FFFF);
    drive(1'b0, 2'd0, 32'hA000_0600, 32'h0);
    #1;
    check("R5 buttons byte", mem_rdata, 32'h6);

    // R4: word store to LED
    drive(1'b1, 2'd2, 32'hA000_0400, 32'h9876_0F0F);
    drive(1'b0, 2'd2, 32'hA000_0400, 32'h0);
    #1;
    check("R4 word store", mem_rdata, 32'h0000_0F0F);

    // R8: reset mid-run clears state
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R8 led after reset", 32'(led_out), 32'h0);
    mem_addr = 32'hA000_0048;
    #1;
    check("R8 counter after reset", mem_rdata, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule